// File: doc/BRIEF.md
# Vertical Filter Configuration Loader

This block is the configuration front end of a vertical image filter. Software, or a sequencer acting for it, drives a 16-bit word bus while an active-low load enable is held low. The first word taken while the loader is idle is an address. That address selects either one of 256 coefficient sets or one of 32 round/limit registers. The words that follow are the data for that target: eight words for a coefficient set, four for a round/limit register. A limit register keeps its lower and upper bounds as separate data words. Reserved bits in the words are expected to be written as zero.

Data words collect in a staging buffer. The target entry is written in one step, on the clock edge that takes the last data word, so the filter never sees a half-updated entry. On the very next cycle the loader expects a new address, so transfers can follow each other with no idle cycle. Loading all coefficient sets takes 256 × 9 = 2304 cycles. Loading all round/limit registers takes 32 × 5 = 160 cycles.

If the enable is raised in the middle of a transfer, the partly staged data is dropped and the loader returns to waiting for an address. The filter datapath reads both stores through registered read ports.

Top module: `vfl_cfg_loader`

## Requirements
- R1: After synchronous reset, `wr_done` is low and the first word taken with `ld_n` low is treated as an address.
- R2: Address word bit 8 selects the target space: 0 selects a coefficient set, indexed by bits [7:0]; 1 selects a round/limit register, indexed by bits [4:0]. Bits [7:5] are ignored for the round/limit space, and all bits above 8 are ignored.
- R3: A coefficient transfer is one address word followed by 8 data words, 9 cycles in total. Data word k lands at `coef_rdata[16k+15:16k]`.
- R4: A round/limit transfer is one address word followed by 4 data words, 5 cycles in total. Data word k lands at `lim_rdata[16k+15:16k]`.
- R5: `wr_done` is high for exactly one cycle, in the cycle after the edge that takes the last data word. It is never high at any other time.
- R6: The target entry keeps its old contents until the last data word is taken. It is then written as a whole in a single step.
- R7: The word that follows the last data word is taken as a new address, so back-to-back transfers need no idle cycle.
- R8: Raising `ld_n` in the middle of a transfer discards the staged words and makes no write. The next word taken with `ld_n` low is an address.
- R9: Words presented while `ld_n` is high cause no write and no `wr_done`.
- R10: A commit changes only its addressed entry. Every other entry in both stores keeps its contents.
- R11: The read ports are registered: `coef_rdata` and `lim_rdata` show the store contents at the presented address one cycle after the address, and a read on the commit edge returns the old contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_n | input | 1 | Active-low load enable |
| din | input | 16 | Address or data word |
| coef_raddr | input | 8 | Coefficient set read index |
| coef_rdata | output | 128 | Coefficient set read data, word 0 in the low bits |
| lim_raddr | input | 5 | Round/limit register read index |
| lim_rdata | output | 64 | Round/limit register read data, word 0 in the low bits |
| wr_done | output | 1 | One-cycle pulse after each commit |

## Verification
The assertions check the sequencer's cycle rules on every cycle:
- a commit is followed by the address state;
- a dropped enable aborts the transfer without `wr_done`;
- an idle enable never writes;
- `wr_done` never lasts two cycles and always follows a write.

Whether the right words reach the right entry in the right lane order can only be shown by the bench scenarios. The same holds for untouched neighbours keeping their values and a mid-transfer read still returning old data. The bench checks these against a behavioural model, using back-to-back, aborted, boundary-index and full-sweep transfers.

// File: rtl/cfl_pkg.sv
package cfl_pkg;
  typedef enum logic {
    ST_ADDR = 1'b0,
    ST_DATA = 1'b1
  } cfl_state_t;
endpackage

// File: rtl/cfl_seq.sv
module cfl_seq #(
  parameter int CIDX_W    = 8,
  parameter int COEF_TAPS = 8,
  parameter int RL_WORDS  = 4,
  parameter int CNT_W     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_n,
  input  logic              addr_sel,
  input  logic [CIDX_W-1:0] addr_idx,
  output logic              stage_we,
  output logic [CNT_W-1:0]  stage_sel,
  output logic              coef_we,
  output logic              lim_we,
  output logic [CIDX_W-1:0] tgt_idx,
  output logic              wr_done
);
  import cfl_pkg::*;

  localparam logic [CNT_W-1:0] C_LAST = CNT_W'(COEF_TAPS - 1);
  localparam logic [CNT_W-1:0] R_LAST = CNT_W'(RL_WORDS - 1);

  cfl_state_t        state_q;
  logic              lim_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CIDX_W-1:0] idx_q;
  logic              done_q;
  logic              is_last, taking, commit;

  always_comb begin
    is_last = lim_q ? (cnt_q == R_LAST) : (cnt_q == C_LAST);
    taking  = (state_q == ST_DATA) && !ld_n;
    commit  = taking && is_last;
  end

  assign stage_we  = taking && !is_last;
  assign stage_sel = cnt_q;
  assign coef_we   = commit && !lim_q;
  assign lim_we    = commit && lim_q;
  assign tgt_idx   = idx_q;
  assign wr_done   = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_ADDR;
      lim_q   <= 1'b0;
      cnt_q   <= '0;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= commit;
      case (state_q)
        ST_ADDR: begin
          if (!ld_n) begin
            lim_q   <= addr_sel;
            idx_q   <= addr_idx;
            cnt_q   <= '0;
            state_q <= ST_DATA;
          end
        end
        default: begin
          if (ld_n || is_last) state_q <= ST_ADDR;
          else                 cnt_q   <= cnt_q + 1'b1;
        end
      endcase
    end
  end

  p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
    wr_done |=> !wr_done);
  p_addr_after_commit_r7: assert property (@(posedge clk) disable iff (rst)
    (coef_we || lim_we) |=> (state_q == ST_ADDR));
  p_abort_drops_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DATA && ld_n) |=> (state_q == ST_ADDR && !wr_done));
  p_idle_holds_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ADDR && ld_n) |=> (state_q == ST_ADDR));
  p_first_slot_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ADDR && !ld_n) |=> (state_q == ST_DATA && cnt_q == '0));
endmodule

// File: rtl/cfl_stage.sv
module cfl_stage #(
  parameter int DW    = 16,
  parameter int DEPTH = 7,
  parameter int CNT_W = 3
) (
  input  logic                clk,
  input  logic                we,
  input  logic [CNT_W-1:0]    sel,
  input  logic [DW-1:0]       din,
  output logic [DEPTH*DW-1:0] flat
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [DW-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (we && sel == CNT_W'(i)) slot_q <= din;
    end
    assign flat[i*DW +: DW] = slot_q;
  end
endmodule

// File: rtl/cfl_bank.sv
module cfl_bank #(
  parameter int W     = 128,
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/vfl_cfg_loader.sv
module vfl_cfg_loader #(
  parameter int DW        = 16,
  parameter int COEF_SETS = 256,
  parameter int COEF_TAPS = 8,
  parameter int RL_REGS   = 32,
  parameter int RL_WORDS  = 4,
  parameter int SEL_BIT   = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          ld_n,
  input  logic [DW-1:0]                 din,
  input  logic [$clog2(COEF_SETS)-1:0]  coef_raddr,
  output logic [COEF_TAPS*DW-1:0]       coef_rdata,
  input  logic [$clog2(RL_REGS)-1:0]    lim_raddr,
  output logic [RL_WORDS*DW-1:0]        lim_rdata,
  output logic                          wr_done
);
  localparam int CIDX_W = $clog2(COEF_SETS);
  localparam int RIDX_W = $clog2(RL_REGS);
  localparam int MAXW   = (COEF_TAPS > RL_WORDS) ? COEF_TAPS : RL_WORDS;
  localparam int CNT_W  = $clog2(MAXW);
  localparam int SDEPTH = MAXW - 1;

  logic                   stage_we, coef_we, lim_we;
  logic [CNT_W-1:0]       stage_sel;
  logic [CIDX_W-1:0]      tgt_idx;
  logic [SDEPTH*DW-1:0]   stage_flat;
  logic [COEF_TAPS*DW-1:0] coef_line;
  logic [RL_WORDS*DW-1:0]  lim_line;

  cfl_seq #(
    .CIDX_W(CIDX_W), .COEF_TAPS(COEF_TAPS), .RL_WORDS(RL_WORDS), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst(rst), .ld_n(ld_n),
    .addr_sel(din[SEL_BIT]), .addr_idx(din[CIDX_W-1:0]),
    .stage_we(stage_we), .stage_sel(stage_sel),
    .coef_we(coef_we), .lim_we(lim_we), .tgt_idx(tgt_idx), .wr_done(wr_done)
  );

  cfl_stage #(.DW(DW), .DEPTH(SDEPTH), .CNT_W(CNT_W)) u_stage (
    .clk(clk), .we(stage_we), .sel(stage_sel), .din(din), .flat(stage_flat)
  );

  // last word bypasses the buffer so the commit lands on its own edge
  assign coef_line = {din, stage_flat[(COEF_TAPS-1)*DW-1:0]};
  assign lim_line  = {din, stage_flat[(RL_WORDS-1)*DW-1:0]};

  cfl_bank #(.W(COEF_TAPS*DW), .DEPTH(COEF_SETS), .AW(CIDX_W)) u_coef (
    .clk(clk), .we(coef_we), .waddr(tgt_idx), .wdata(coef_line),
    .raddr(coef_raddr), .rdata(coef_rdata)
  );

  cfl_bank #(.W(RL_WORDS*DW), .DEPTH(RL_REGS), .AW(RIDX_W)) u_lim (
    .clk(clk), .we(lim_we), .waddr(tgt_idx[RIDX_W-1:0]), .wdata(lim_line),
    .raddr(lim_raddr), .rdata(lim_rdata)
  );

  p_idle_no_write_r9: assert property (@(posedge clk) disable iff (rst)
    ld_n |-> !(coef_we || lim_we));
  p_done_after_write_r5: assert property (@(posedge clk) disable iff (rst)
    (coef_we || lim_we) |=> wr_done);
  p_one_target_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({coef_we, lim_we}));
endmodule

// File: tb/vfl_cfg_loader_tb.sv
`timescale 1ns/1ps
module vfl_cfg_loader_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ld_n = 1'b1;
  logic [15:0]  din = '0;
  logic [7:0]   coef_raddr = '0;
  logic [127:0] coef_rdata;
  logic [4:0]   lim_raddr = '0;
  logic [63:0]  lim_rdata;
  logic         wr_done;

  always #10 clk = ~clk;

  vfl_cfg_loader dut_i (
    .clk(clk), .rst(rst), .ld_n(ld_n), .din(din),
    .coef_raddr(coef_raddr), .coef_rdata(coef_rdata),
    .lim_raddr(lim_raddr), .lim_rdata(lim_rdata), .wr_done(wr_done)
  );

  int n_chk = 0, n_err = 0, n_pulse = 0, n_commit = 0;
  bit chk_on = 0, ended = 0;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  // behavioural reference model
  logic [127:0] mc [256];
  logic [63:0]  mr [32];
  bit           mv_c [256];
  bit           mv_r [32];
  logic [15:0]  m_q [$];
  bit m_busy, m_sp;
  int m_idx, m_need;
  bit e_done, e_cok, e_rok;
  logic [127:0] e_c;
  logic [63:0]  e_r;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_q.delete(); e_done = 0; e_cok = 0; e_rok = 0;
    end else begin
      logic [127:0] line;
      e_cok = mv_c[coef_raddr]; e_c = mc[coef_raddr];
      e_rok = mv_r[lim_raddr];  e_r = mr[lim_raddr];
      e_done = 0;
      if (ld_n) begin
        m_busy = 0;
      end else if (!m_busy) begin
        m_sp = din[8];
        m_idx = m_sp ? int'(din[4:0]) : int'(din[7:0]);
        m_need = m_sp ? 4 : 8;
        m_q.delete();
        m_busy = 1;
      end else begin
        m_q.push_back(din);
        if (m_q.size() == m_need) begin
          line = '0;
          foreach (m_q[k]) line[k*16 +: 16] = m_q[k];
          if (m_sp) begin mr[m_idx] = line[63:0]; mv_r[m_idx] = 1; end
          else      begin mc[m_idx] = line;       mv_c[m_idx] = 1; end
          e_done = 1; m_busy = 0; n_commit++;
        end
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (chk_on) begin
      if (wr_done) n_pulse++;
      chk(wr_done === e_done, "R5 wr_done cycle", {127'b0, wr_done}, {127'b0, e_done});
      if (e_cok) chk(coef_rdata === e_c, "R11 coef read", coef_rdata, e_c);
      if (e_rok) chk(lim_rdata === e_r, "R11 limit read", {64'b0, lim_rdata}, {64'b0, e_r});
    end
  end

  function automatic logic [15:0] cw(input int s, input int k, input int salt);
    return 16'((s * 37 + k * 1103 + salt * 7919) & 16'hFFFF);
  endfunction
  function automatic logic [127:0] cline(input int s, input int salt);
    logic [127:0] v;
    for (int k = 0; k < 8; k++) v[k*16 +: 16] = cw(s, k, salt);
    return v;
  endfunction
  function automatic logic [63:0] rline(input int r, input int salt);
    logic [63:0] v;
    for (int k = 0; k < 4; k++) v[k*16 +: 16] = cw(r + 300, k, salt);
    return v;
  endfunction

  task automatic snd(input logic [15:0] w);
    @(negedge clk); ld_n = 1'b0; din = w;
  endtask
  task automatic idle();
    @(negedge clk); ld_n = 1'b1; din = 16'hA5A5;
  endtask
  task automatic xfer_c(input int s, input int salt);
    snd(16'(s & 255));
    for (int k = 0; k < 8; k++) snd(cw(s, k, salt));
  endtask
  task automatic xfer_r(input logic [15:0] aw, input int r, input int salt);
    snd(aw);
    for (int k = 0; k < 4; k++) snd(cw(r + 300, k, salt));
  endtask
  task automatic rd_c(input int s, output logic [127:0] v);
    @(negedge clk); coef_raddr = 8'(s);
    @(negedge clk); v = coef_rdata;
  endtask
  task automatic rd_r(input int r, output logic [63:0] v);
    @(negedge clk); lim_raddr = 5'(r);
    @(negedge clk); v = lim_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [127:0] vc;
    logic [63:0]  vr;
    int p0;
    repeat (4) @(negedge clk);
    rst = 1'b0; chk_on = 1;
    @(negedge clk);
    chk(wr_done === 1'b0, "R1 reset wr_done", {127'b0, wr_done}, 128'b0);

    // R1 R3: first transfer after reset, plus neighbours for R10
    xfer_c(5, 1); xfer_c(4, 1); xfer_c(6, 1); idle();
    rd_c(5, vc); chk(vc === cline(5, 1), "R3 coef lanes", vc, cline(5, 1));

    // R4: limit register with lower/upper halves
    xfer_r(16'h0107, 7, 1); idle();
    rd_r(7, vr); chk(vr === rline(7, 1), "R4 limit lanes", {64'b0, vr}, {64'b0, rline(7, 1)});

    // R7: back-to-back transfers, no idle cycle
    xfer_c(10, 2); xfer_r(16'h0103, 3, 2); xfer_c(11, 2); idle();
    rd_c(10, vc); chk(vc === cline(10, 2), "R7 back-to-back first", vc, cline(10, 2));
    rd_r(3, vr);  chk(vr === rline(3, 2), "R7 back-to-back middle", {64'b0, vr}, {64'b0, rline(3, 2)});
    rd_c(11, vc); chk(vc === cline(11, 2), "R7 back-to-back last", vc, cline(11, 2));

    // R8: abort mid transfer
    snd(16'd5); for (int k = 0; k < 4; k++) snd(16'hDEAD); idle();
    rd_c(5, vc); chk(vc === cline(5, 1), "R8 aborted coef kept", vc, cline(5, 1));
    snd(16'h0107); snd(16'hBEEF); snd(16'hBEEF); idle();
    xfer_r(16'h0109, 9, 3); idle();
    rd_r(9, vr); chk(vr === rline(9, 3), "R8 address after abort", {64'b0, vr}, {64'b0, rline(9, 3)});
    rd_r(7, vr); chk(vr === rline(7, 1), "R8 aborted limit kept", {64'b0, vr}, {64'b0, rline(7, 1)});

    // R9: words with enable high do nothing
    p0 = n_pulse;
    for (int k = 0; k < 12; k++) begin @(negedge clk); ld_n = 1'b1; din = 16'(k * 4099); end
    chk(n_pulse == p0, "R9 no done while idle", 128'(n_pulse - p0), 128'b0);
    rd_c(5, vc); chk(vc === cline(5, 1), "R9 idle words ignored", vc, cline(5, 1));

    // R6: old contents visible until the last word
    @(negedge clk); coef_raddr = 8'd5;
    snd(16'd5);
    for (int k = 0; k < 7; k++) snd(cw(5, k, 4));
    @(negedge clk);
    chk(coef_rdata === cline(5, 1), "R6 old data before last word", coef_rdata, cline(5, 1));
    ld_n = 1'b0; din = cw(5, 7, 4);
    idle();
    rd_c(5, vc); chk(vc === cline(5, 4), "R6 whole entry committed", vc, cline(5, 4));

    // R10: neighbours untouched
    rd_c(4, vc); chk(vc === cline(4, 1), "R10 neighbour below", vc, cline(4, 1));
    rd_c(6, vc); chk(vc === cline(6, 1), "R10 neighbour above", vc, cline(6, 1));

    // R2: boundary indices and ignored address bits
    xfer_c(255, 5); xfer_r(16'h011F, 31, 5); xfer_r(16'hF1E2, 2, 5); idle();
    rd_c(255, vc); chk(vc === cline(255, 5), "R2 coef index 255", vc, cline(255, 5));
    rd_r(31, vr);  chk(vr === rline(31, 5), "R2 limit index 31", {64'b0, vr}, {64'b0, rline(31, 5)});
    rd_r(2, vr);   chk(vr === rline(2, 5), "R2 upper address bits ignored", {64'b0, vr}, {64'b0, rline(2, 5)});

    // R4 R5: full sweep of limit registers, one pulse per register
    p0 = n_pulse;
    for (int r = 0; r < 32; r++) xfer_r(16'(16'h0100 | r), r, 6);
    idle(); @(negedge clk);
    chk(n_pulse - p0 == 32, "R5 sweep pulse count", 128'(n_pulse - p0), 128'd32);
    rd_r(17, vr); chk(vr === rline(17, 6), "R4 sweep entry", {64'b0, vr}, {64'b0, rline(17, 6)});

    repeat (3) @(negedge clk);
    chk(n_pulse == n_commit, "R5 total pulses", 128'(n_pulse), 128'(n_commit));
    finish_run();
  end
endmodule